// File: doc/BRIEF.md
# Consecutive-Hit Window Lock Detector

This block decides whether a phase-locked loop has settled. It runs on a fast sampling clock and receives two single-cycle pulse streams: one marks each divided reference edge, the other marks each divided oscillator edge. Around every reference pulse it places an acceptance window whose length is a programmable number of fast-clock cycles. For each reference cycle it gives a verdict: a hit if at least one oscillator pulse fell inside the window, a miss otherwise. A run of consecutive hits that reaches a programmed target raises the lock flag. A single miss drops the flag and restarts the run.

The window can be centred on the reference edge, placed wholly after it or placed wholly before it. The one-sided placements suit a loop that runs with a deliberate phase offset between the two edges, so that the window can stay narrow while still covering the expected arrival. Reference pulses are expected to be at least twice the window length plus two cycles apart, so that consecutive windows never overlap.

Top module: `lockwin_detector`

## Requirements
- R1: While `det_en` is 0 or `test_mode` is 1 the detector is idle: `lock_flag` is 0 from the next cycle, the hit run is cleared and reference pulses give no verdict.
- R2: Each hit verdict adds one to the run; when the run reaches `run_target`, `lock_flag` is 1 from the cycle after that verdict and stays 1 while hits continue.
- R3: A miss verdict clears `lock_flag` in the cycle after it and restarts the run at zero, so a full new run of `run_target` hits is needed to lock again.
- R4: The window spans exactly `win_len` fast-clock cycles; with `win_len` of 0 every verdict is a miss.
- R5: With `skew_en` = 0 (centred) and a reference pulse in cycle t, the window covers cycles t-floor(W/2) to t-floor(W/2)+W-1, where W is `win_len`; the verdict is given in the last cycle of that span (or in cycle t if that is later).
- R6: With `skew_en` = 1 and `skew_late` = 1 (late), the window covers cycles t+1 to t+W and the verdict is given in cycle t+W; an oscillator pulse in cycle t itself does not count.
- R7: With `skew_en` = 1 and `skew_late` = 0 (early), the window covers cycles t-W to t-1 and the verdict is given in cycle t; an oscillator pulse in cycle t itself does not count.
- R8: A reference cycle with no oscillator pulse in its window is a miss; oscillator pulses that fall outside every window have no effect on the run or the flag.
- R9: The run counter saturates at its all-ones value (`2**RUN_W-1`) and never wraps, so with `run_target` at that value the flag stays 1 through any number of further hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detector enable; 0 holds the detector idle |
| test_mode | input | 1 | 1 suspends detection (idle) |
| skew_en | input | 1 | 1 selects a one-sided window, 0 a centred one |
| skew_late | input | 1 | With `skew_en`: 1 places the window after the reference, 0 before it |
| win_len | input | WIN_W | Window length in fast-clock cycles |
| run_target | input | RUN_W | Consecutive hits needed for lock |
| ref_pulse | input | 1 | One-cycle pulse per divided reference edge |
| vco_pulse | input | 1 | One-cycle pulse per divided oscillator edge |
| lock_flag | output | 1 | Lock indication |

## Verification
The hardest state to reach is saturation of the run counter: it needs thousands of unbroken hits before the counter sits at its top value, and only then does a further hit show whether it wraps. The stimulus uses the late window with a two-cycle length and a short reference spacing, sets the target to the all-ones value and drives just over four thousand hits, comparing the flag against the reference model every cycle so that a wrap would show up as an early drop. The window edges are reached by placing the oscillator pulse exactly on the first and last cycle of each placement and one cycle beyond them, including the reference cycle itself.

// File: rtl/lockwin_pkg.sv
package lockwin_pkg;

   typedef enum logic [1:0] {
      PLACE_CENTRED = 2'd0,
      PLACE_LATE    = 2'd1,
      PLACE_EARLY   = 2'd2
   } win_place_e;

   function automatic win_place_e decode_place(input logic one_sided, input logic late);
      if (!one_sided)
         return PLACE_CENTRED;
      else if (late)
         return PLACE_LATE;
      else
         return PLACE_EARLY;
   endfunction

endpackage

// File: rtl/lockwin_shape.sv
module lockwin_shape
   import lockwin_pkg::*;
#(
   parameter int WIN_W = 6
) (
   input  win_place_e         place,
   input  logic [WIN_W-1:0]   len,
   output logic [WIN_W-1:0]   back_span,
   output logic [WIN_W-1:0]   fwd_span,
   output logic               incl_edge
);

   logic [WIN_W-1:0] half_len;

   assign half_len = len >> 1;

   always_comb begin
      back_span = '0;
      fwd_span  = '0;
      incl_edge = 1'b0;
      if (len != '0) begin
         unique case (place)
            PLACE_LATE: begin
               fwd_span = len;
            end
            PLACE_EARLY: begin
               back_span = len;
            end
            default: begin
               back_span = half_len;
               fwd_span  = len - half_len - 1'b1;
               incl_edge = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/lockwin_vco_age.sv
module lockwin_vco_age #(
   parameter int AGE_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vco_pulse,
   output logic [AGE_W-1:0] age
);

   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= '1;
      else if (vco_pulse)
         age_q <= {{(AGE_W-1){1'b0}}, 1'b1};
      else if (age_q != '1)
         age_q <= age_q + 1'b1;
   end

   assign age = age_q;

endmodule

// File: rtl/lockwin_eval.sv
module lockwin_eval #(
   parameter int WIN_W = 6,
   parameter int AGE_W = WIN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ref_pulse,
   input  logic             vco_pulse,
   input  logic [AGE_W-1:0] age,
   input  logic [WIN_W-1:0] back_span,
   input  logic [WIN_W-1:0] fwd_span,
   input  logic             incl_edge,
   output logic             verdict_valid,
   output logic             verdict_hit
);

   localparam int PAD_W = AGE_W - WIN_W;

   logic [WIN_W-1:0] left_q, left_d;
   logic             found_q, found_d;
   logic             near_hit;
   logic             seen;

   assign near_hit = (age <= {{PAD_W{1'b0}}, back_span}) | (incl_edge & vco_pulse);
   assign seen     = found_q | vco_pulse;

   always_comb begin
      left_d        = left_q;
      found_d       = found_q;
      verdict_valid = 1'b0;
      verdict_hit   = 1'b0;
      if (!active) begin
         left_d  = '0;
         found_d = 1'b0;
      end else if (ref_pulse) begin
         if (fwd_span == '0) begin
            verdict_valid = 1'b1;
            verdict_hit   = near_hit;
            left_d        = '0;
            found_d       = 1'b0;
         end else begin
            left_d  = fwd_span;
            found_d = near_hit;
         end
      end else if (left_q != '0) begin
         left_d  = left_q - 1'b1;
         found_d = seen;
         if (left_q == {{(WIN_W-1){1'b0}}, 1'b1}) begin
            verdict_valid = 1'b1;
            verdict_hit   = seen;
            found_d       = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         found_q <= 1'b0;
      end else begin
         left_q  <= left_d;
         found_q <= found_d;
      end
   end

endmodule

// File: rtl/lockwin_run.sv
module lockwin_run #(
   parameter int RUN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             verdict_valid,
   input  logic             verdict_hit,
   input  logic [RUN_W-1:0] target,
   output logic [RUN_W-1:0] run_cnt,
   output logic             lock_flag
);

   logic [RUN_W-1:0] cnt_q, cnt_inc;
   logic             lock_q;

   assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
      end else if (!active) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
      end else if (verdict_valid) begin
         if (verdict_hit) begin
            cnt_q  <= cnt_inc;
            lock_q <= (cnt_inc >= target);
         end else begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
         end
      end
   end

   assign run_cnt   = cnt_q;
   assign lock_flag = lock_q;

endmodule

// File: rtl/lockwin_detector.sv
module lockwin_detector
   import lockwin_pkg::*;
#(
   parameter int WIN_W = 6,
   parameter int RUN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_en,
   input  logic             test_mode,
   input  logic             skew_en,
   input  logic             skew_late,
   input  logic [WIN_W-1:0] win_len,
   input  logic [RUN_W-1:0] run_target,
   input  logic             ref_pulse,
   input  logic             vco_pulse,
   output logic             lock_flag
);

   localparam int AGE_W = WIN_W + 1;

   if (WIN_W < 2 || WIN_W > 16) begin : g_bad_win_w
      $error("lockwin_detector: WIN_W must lie in 2..16");
   end
   if (RUN_W < 2 || RUN_W > 24) begin : g_bad_run_w
      $error("lockwin_detector: RUN_W must lie in 2..24");
   end

   win_place_e       place;
   logic             active;
   logic [WIN_W-1:0] back_span;
   logic [WIN_W-1:0] fwd_span;
   logic             incl_edge;
   logic [AGE_W-1:0] vco_age;
   logic             verdict_valid;
   logic             verdict_hit;
   logic [RUN_W-1:0] run_cnt;

   assign active = det_en & ~test_mode;
   assign place  = decode_place(skew_en, skew_late);

   lockwin_shape #(.WIN_W(WIN_W)) u_shape (
      .place     (place),
      .len       (win_len),
      .back_span (back_span),
      .fwd_span  (fwd_span),
      .incl_edge (incl_edge)
   );

   lockwin_vco_age #(.AGE_W(AGE_W)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .vco_pulse (vco_pulse),
      .age       (vco_age)
   );

   lockwin_eval #(.WIN_W(WIN_W), .AGE_W(AGE_W)) u_eval (
      .clk           (clk),
      .rst_n         (rst_n),
      .active        (active),
      .ref_pulse     (ref_pulse),
      .vco_pulse     (vco_pulse),
      .age           (vco_age),
      .back_span     (back_span),
      .fwd_span      (fwd_span),
      .incl_edge     (incl_edge),
      .verdict_valid (verdict_valid),
      .verdict_hit   (verdict_hit)
   );

   lockwin_run #(.RUN_W(RUN_W)) u_run (
      .clk           (clk),
      .rst_n         (rst_n),
      .active        (active),
      .verdict_valid (verdict_valid),
      .verdict_hit   (verdict_hit),
      .target        (run_target),
      .run_cnt       (run_cnt),
      .lock_flag     (lock_flag)
   );

endmodule

// File: rtl/lockwin_detector_chk.sv
module lockwin_detector_chk #(
   parameter int WIN_W = 6,
   parameter int RUN_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             active,
   input logic             lock_flag,
   input logic             verdict_valid,
   input logic             verdict_hit,
   input logic [RUN_W-1:0] run_cnt,
   input logic [WIN_W-1:0] win_len
);

   p_idle_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!lock_flag && run_cnt == '0));

   p_no_verdict_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |-> active);

   p_rise_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_flag) |-> $past(verdict_valid && verdict_hit));

   p_hit_steps_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && verdict_valid && verdict_hit && run_cnt != '1) |=> run_cnt == $past(run_cnt) + 1'b1);

   p_miss_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && verdict_valid && !verdict_hit) |=> (!lock_flag && run_cnt == '0));

   p_empty_misses_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_valid && win_len == '0) |-> !verdict_hit);

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && verdict_valid && verdict_hit && run_cnt == '1) |=> run_cnt == '1);

endmodule

bind lockwin_detector lockwin_detector_chk #(.WIN_W(WIN_W), .RUN_W(RUN_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .active        (active),
   .lock_flag     (lock_flag),
   .verdict_valid (verdict_valid),
   .verdict_hit   (verdict_hit),
   .run_cnt       (run_cnt),
   .win_len       (win_len)
);

// File: tb/lockwin_detector_bench.sv
`timescale 1ns/1ps
module lockwin_detector_bench;

   localparam int WIN_W   = 6;
   localparam int RUN_W   = 12;
   localparam int RUN_MAX = (1 << RUN_W) - 1;
   localparam int NO_VCO  = 999;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             det_en = 1'b0;
   logic             test_mode = 1'b0;
   logic             skew_en = 1'b0;
   logic             skew_late = 1'b0;
   logic [WIN_W-1:0] win_len = '0;
   logic [RUN_W-1:0] run_target = '0;
   logic             ref_pulse = 1'b0;
   logic             vco_pulse = 1'b0;
   logic             lock_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lockwin_detector #(.WIN_W(WIN_W), .RUN_W(RUN_W)) u_lockwin_detector (
      .clk        (clk),
      .rst_n      (rst_n),
      .det_en     (det_en),
      .test_mode  (test_mode),
      .skew_en    (skew_en),
      .skew_late  (skew_late),
      .win_len    (win_len),
      .run_target (run_target),
      .ref_pulse  (ref_pulse),
      .vco_pulse  (vco_pulse),
      .lock_flag  (lock_flag)
   );

   // behavioural model state
   int cyc = 0;
   int vco_hist[$];
   bit pend = 0;
   bit pend_empty = 0;
   int pend_lo, pend_hi, pend_dec;
   int m_cnt = 0;
   bit m_lock = 0;
   int off_tab[64];

   task automatic check(input string tag, input bit got, input bit exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: lock_flag=%0b expected %0b (cycle %0d)", tag, got, exp, cyc);
      end
   endtask

   task automatic model_step();
      bit hit;
      int w;
      int lo;
      int hi;
      if (vco_pulse) vco_hist.push_back(cyc);
      while (vco_hist.size() > 0 && vco_hist[0] < cyc - 300) void'(vco_hist.pop_front());
      if (!det_en || test_mode) begin
         m_cnt  = 0;
         m_lock = 0;
         pend   = 0;
      end else begin
         if (ref_pulse) begin
            w = int'(win_len);
            if (!skew_en) begin
               lo = cyc - w / 2;
               hi = lo + w - 1;
            end else if (skew_late) begin
               lo = cyc + 1;
               hi = cyc + w;
            end else begin
               lo = cyc - w;
               hi = cyc - 1;
            end
            pend       = 1;
            pend_empty = (w == 0);
            pend_lo    = lo;
            pend_hi    = hi;
            pend_dec   = (w == 0 || hi < cyc) ? cyc : hi;
         end
         if (pend && pend_dec == cyc) begin
            hit = 0;
            if (!pend_empty)
               foreach (vco_hist[i])
                  if (vco_hist[i] >= pend_lo && vco_hist[i] <= pend_hi) hit = 1;
            pend = 0;
            if (hit) begin
               if (m_cnt < RUN_MAX) m_cnt++;
               m_lock = (m_cnt >= int'(run_target));
            end else begin
               m_cnt  = 0;
               m_lock = 0;
            end
         end
      end
      cyc++;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag, lock_flag, m_lock);
   endtask

   task automatic idle(input int n, input string tag);
      ref_pulse = 0;
      vco_pulse = 0;
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic setup(input bit se, input bit sl, input int w, input int tgt);
      det_en = 0;
      ref_pulse = 0;
      vco_pulse = 0;
      idle(2, "R1");
      skew_en    = se;
      skew_late  = sl;
      win_len    = WIN_W'(w);
      run_target = RUN_W'(tgt);
      det_en     = 1;
   endtask

   task automatic run_refs(input int n, input int w, input string tag, input bit stray);
      int p;
      int o;
      p = 2 * w + 4;
      for (int k = 0; k < n; k++) begin
         o = off_tab[k % 64];
         for (int j = 0; j < p; j++) begin
            ref_pulse = (j == w + 1);
            vco_pulse = (o != NO_VCO && j == w + 1 + o) || (stray && j == p - 1);
            step(tag);
         end
      end
      ref_pulse = 0;
      vco_pulse = 0;
   endtask

   task automatic fill(input int v);
      for (int i = 0; i < 64; i++) off_tab[i] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete (expected completion)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", lock_flag, 1'b0);
      rst_n = 1;
      idle(3, "R1");

      // R2: run of hits on a centred window reaches the target
      setup(0, 0, 5, 6);
      fill(0);
      run_refs(10, 5, "R2", 0);
      check("R2 locked", lock_flag, 1'b1);

      // R3 and R8: a missing arrival drops lock and restarts the run
      setup(0, 0, 5, 3);
      fill(1);
      off_tab[5] = NO_VCO;
      run_refs(12, 5, "R3", 0);
      check("R3 relocked", lock_flag, 1'b1);

      // R5: centred window edges, odd and even length
      setup(0, 0, 5, 1);
      fill(0);
      off_tab[0] = -2; off_tab[1] = 2; off_tab[2] = -3; off_tab[3] = 2;
      off_tab[4] = 3;  off_tab[5] = -1; off_tab[6] = 0;
      run_refs(7, 5, "R5", 0);
      setup(0, 0, 4, 1);
      fill(0);
      off_tab[0] = 1; off_tab[1] = 2; off_tab[2] = -2; off_tab[3] = -3; off_tab[4] = 0;
      run_refs(5, 4, "R5", 0);

      // R6: late window, reference cycle itself excluded
      setup(1, 1, 4, 1);
      fill(1);
      off_tab[1] = 4; off_tab[2] = 0; off_tab[3] = 2; off_tab[4] = 5; off_tab[5] = 1;
      run_refs(6, 4, "R6", 0);

      // R7: early window, reference cycle itself excluded
      setup(1, 0, 4, 1);
      fill(-1);
      off_tab[1] = -4; off_tab[2] = 0; off_tab[3] = -2; off_tab[4] = -5; off_tab[5] = -1;
      run_refs(6, 4, "R7", 0);

      // R4: zero-length window never hits, length one covers only the edge
      setup(0, 0, 0, 1);
      fill(0);
      run_refs(4, 0, "R4", 0);
      check("R4 empty", lock_flag, 1'b0);
      setup(0, 0, 1, 2);
      fill(0);
      off_tab[3] = 1;
      run_refs(6, 1, "R4", 0);

      // R8: stray arrivals outside the windows leave the run alone
      setup(1, 1, 3, 4);
      fill(2);
      run_refs(8, 3, "R8", 1);
      check("R8 stray ignored", lock_flag, 1'b1);

      // R1: disable and test mode while locked
      setup(0, 0, 3, 2);
      fill(0);
      run_refs(4, 3, "R1", 0);
      det_en = 0;
      run_refs(3, 3, "R1", 0);
      det_en = 1;
      run_refs(3, 3, "R1", 0);
      test_mode = 1;
      run_refs(3, 3, "R1", 0);
      check("R1 test mode", lock_flag, 1'b0);
      test_mode = 0;
      run_refs(3, 3, "R1", 0);

      // R9: saturation at the all-ones count
      setup(1, 1, 2, RUN_MAX);
      fill(1);
      run_refs(RUN_MAX + 10, 2, "R9", 0);
      check("R9 saturated", lock_flag, 1'b1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule